// File: doc/BRIEF.md
# Adjustable Micro-Frame Start Timer

This block paces a high-speed serial bus host. It counts cycles of the 480 MHz bit clock and emits a start-of-frame strobe at the end of every micro-frame. The host uses this strobe to begin each micro-frame's traffic. A running micro-frame index advances with each strobe so the host can tell micro-frames apart.

The micro-frame length is 59488 clocks plus 16 clocks per step of a 6-bit trim. The trim is held in a byte-wide register that software can read and write, and it corrects for offset in the clock source. The default trim of 32 gives 60000 clocks, which is 125 µs at 480 MHz. The trim register sits in the always-on power well and has its own reset. A core reset therefore clears the counter and the index but keeps the trim. A write to the register takes effect only while the controller is halted. A write made while the controller is running is dropped.

Top module: `sof_timer_top`

## Requirements
- R1: A register write made while `run_i` is low stores `reg_wdata_i[5:0]` as the trim. The read port always returns `{2'b00, trim}` combinationally. Bits 7:6 read as zero whatever was written to them, and a read has no side effects.
- R2: `aon_rst_ni` low sets the trim to 6'h20, so the read port shows 8'h20.
- R3: While running, `sof_o` is high for exactly one clock, once every BASE_LEN + STEP_LEN × trim clocks. By default this is 59488 + 16 × trim, for example 59488 clocks at trim 0.
- R4: With the reset trim of 32, the first start-of-frame strobe comes 60000 clocks after running begins.
- R5: A register write made while `run_i` is high leaves the stored trim unchanged.
- R6: `core_rst_ni` does not change the stored trim.
- R7: While `run_i` is low, no strobe is issued and the index holds its value. After `run_i` rises, the first strobe appears in the clock cycle that is one full micro-frame long counted from the first running cycle, so a length of L puts it in the L-th cycle. A trim written while halted sets the length of the next micro-frame.
- R8: The micro-frame index (IDX_W bits, 14 by default) increments by one after every strobe. It wraps to zero after its all-ones value and clears on `core_rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock, the high-speed bit clock |
| core_rst_ni | input | 1 | Asynchronous active-low core reset for the counter and index |
| aon_rst_ni | input | 1 | Asynchronous active-low always-on-well reset for the trim |
| run_i | input | 1 | High means run, low means halted |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, `{2'b00, trim}` |
| sof_o | output | 1 | One-clock start-of-frame strobe |
| uframe_idx_o | output | IDX_W | Running micro-frame index |

## Verification
The assertions assume that `run_i` stays low for at least one clock after `core_rst_ni` is released. They also assume that `run_i` rises at least one clock after the last halted write. This gives the counter time to reload from the current trim before it counts, and it keeps the counter bound and the single-cycle strobe checks valid. The stimulus drives every input on the falling clock edge. It always spends one halted cycle after each write or reset before it raises run. It makes random register writes both while halted and while running, and it checks frame lengths drawn at random from the full trim range on a reduced-length instance. It then checks the default-length instance directly at trims 32 and 0.

// File: rtl/sof_pkg.sv
package sof_pkg;
    // Software-visible register width of the trim register.
    localparam int unsigned SOF_REG_W = 8;

    // Micro-frame length in counter clocks for a given trim.
    function automatic int unsigned sof_len(input int unsigned base_len,
                                            input int unsigned step_len,
                                            input int unsigned trim);
        return base_len + step_len * trim;
    endfunction
endpackage

// File: rtl/sof_trim_reg.sv
module sof_trim_reg #(
    parameter int unsigned TRIM_W   = 6,
    parameter int unsigned REG_W    = sof_pkg::SOF_REG_W,
    parameter int unsigned TRIM_RST = 32
) (
    input  logic              clk_i,
    input  logic              aon_rst_ni,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic [REG_W-1:0]  rd_data_o
);
    localparam int unsigned PAD_W = REG_W - TRIM_W;

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
    } trim_state_t;

    trim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && !run_i) begin
            st_d.trim = wr_data_i[TRIM_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge aon_rst_ni) begin
        if (!aon_rst_ni) begin
            st_q.trim <= TRIM_W'(TRIM_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign trim_o    = st_q.trim;
    assign rd_data_o = {{PAD_W{1'b0}}, st_q.trim};

    // A halted write lands in the stored trim.
    assert_write_lands_R1: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
        (wr_en_i && !run_i) |=> (trim_o == $past(wr_data_i[TRIM_W-1:0])));

    // While running the trim cannot move.
    assert_run_locks_R5: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
        run_i |=> $stable(trim_o));
endmodule

// File: rtl/sof_down_counter.sv
module sof_down_counter #(
    parameter int unsigned BASE_LEN = 59488,
    parameter int unsigned STEP_LEN = 16,
    parameter int unsigned TRIM_W   = 6,
    parameter int unsigned TRIM_RST = 32
) (
    input  logic              clk_i,
    input  logic              core_rst_ni,
    input  logic              run_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic              sof_o
);
    localparam int unsigned MAX_LEN = sof_pkg::sof_len(BASE_LEN, STEP_LEN, (2 ** TRIM_W) - 1);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN);
    localparam int unsigned RST_LEN = sof_pkg::sof_len(BASE_LEN, STEP_LEN, TRIM_RST);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [31:0]      len_full;
    logic [CNT_W-1:0] reload;
    logic             at_zero;

    always_comb begin
        len_full = sof_pkg::sof_len(BASE_LEN, STEP_LEN, 32'(trim_i));
        reload   = CNT_W'(len_full - 32'd1);
        at_zero  = (st_q.cnt == '0);
        st_d     = st_q;
        if (!run_i || at_zero) begin
            st_d.cnt = reload;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge core_rst_ni) begin
        if (!core_rst_ni) begin
            st_q.cnt <= CNT_W'(RST_LEN - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign sof_o = run_i && at_zero;

    // Strobe lasts exactly one clock (lengths are at least two).
    assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
        sof_o |=> !sof_o);

    // A running count never exceeds the current reload point.
    assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
        run_i |-> (st_q.cnt <= reload));
endmodule

// File: rtl/sof_frame_index.sv
module sof_frame_index #(
    parameter int unsigned IDX_W = 14
) (
    input  logic             clk_i,
    input  logic             core_rst_ni,
    input  logic             sof_i,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_state_t;

    idx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sof_i) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge core_rst_ni) begin
        if (!core_rst_ni) begin
            st_q.idx <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = st_q.idx;

    // Index is quiet between strobes.
    assert_idx_quiet_R8: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
        !sof_i |=> $stable(idx_o));
endmodule

// File: rtl/sof_timer_top.sv
module sof_timer_top #(
    parameter int unsigned BASE_LEN = 59488,
    parameter int unsigned STEP_LEN = 16,
    parameter int unsigned TRIM_W   = 6,
    parameter int unsigned TRIM_RST = 32,
    parameter int unsigned IDX_W    = 14
) (
    input  logic                          clk_i,
    input  logic                          core_rst_ni,
    input  logic                          aon_rst_ni,
    input  logic                          run_i,
    input  logic                          reg_wr_i,
    input  logic [sof_pkg::SOF_REG_W-1:0] reg_wdata_i,
    output logic [sof_pkg::SOF_REG_W-1:0] reg_rdata_o,
    output logic                          sof_o,
    output logic [IDX_W-1:0]              uframe_idx_o
);
    logic [TRIM_W-1:0] trim;
    logic              sof;

    sof_trim_reg #(
        .TRIM_W   (TRIM_W),
        .REG_W    (sof_pkg::SOF_REG_W),
        .TRIM_RST (TRIM_RST)
    ) trim_i (
        .clk_i     (clk_i),
        .aon_rst_ni(aon_rst_ni),
        .run_i     (run_i),
        .wr_en_i   (reg_wr_i),
        .wr_data_i (reg_wdata_i),
        .trim_o    (trim),
        .rd_data_o (reg_rdata_o)
    );

    sof_down_counter #(
        .BASE_LEN (BASE_LEN),
        .STEP_LEN (STEP_LEN),
        .TRIM_W   (TRIM_W),
        .TRIM_RST (TRIM_RST)
    ) cnt_i (
        .clk_i      (clk_i),
        .core_rst_ni(core_rst_ni),
        .run_i      (run_i),
        .trim_i     (trim),
        .sof_o      (sof)
    );

    sof_frame_index #(
        .IDX_W (IDX_W)
    ) idx_i (
        .clk_i      (clk_i),
        .core_rst_ni(core_rst_ni),
        .sof_i      (sof),
        .idx_o      (uframe_idx_o)
    );

    assign sof_o = sof;
endmodule

// File: tb/sof_timer_top_tb_top.sv
module sof_timer_top_tb_top;
    localparam int unsigned S_BASE = 24;
    localparam int unsigned S_STEP = 2;
    localparam int unsigned S_IDXW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // default-length instance
    logic        d_core_rst_n = 1'b0, d_aon_rst_n = 1'b0, d_run = 1'b0, d_wr = 1'b0;
    logic [7:0]  d_wdata = '0, d_rdata;
    logic        d_sof;
    logic [13:0] d_idx;

    // reduced-length instance
    logic              s_core_rst_n = 1'b0, s_aon_rst_n = 1'b0, s_run = 1'b0, s_wr = 1'b0;
    logic [7:0]        s_wdata = '0, s_rdata;
    logic              s_sof;
    logic [S_IDXW-1:0] s_idx;

    sof_timer_top dut_i (
        .clk_i(clk), .core_rst_ni(d_core_rst_n), .aon_rst_ni(d_aon_rst_n),
        .run_i(d_run), .reg_wr_i(d_wr), .reg_wdata_i(d_wdata),
        .reg_rdata_o(d_rdata), .sof_o(d_sof), .uframe_idx_o(d_idx));

    sof_timer_top #(.BASE_LEN(S_BASE), .STEP_LEN(S_STEP), .IDX_W(S_IDXW)) dut_small_i (
        .clk_i(clk), .core_rst_ni(s_core_rst_n), .aon_rst_ni(s_aon_rst_n),
        .run_i(s_run), .reg_wr_i(s_wr), .reg_wdata_i(s_wdata),
        .reg_rdata_o(s_rdata), .sof_o(s_sof), .uframe_idx_o(s_idx));

    function automatic int exp_len(int base, int step, int v);
        return base + step * v;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] d);
        return {2'b00, d[5:0]};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic s_write(logic [7:0] d);
        s_wr = 1'b1; s_wdata = d;
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    // Run the small instance for n frames of length len, then halt.
    task automatic run_small(int n, int len);
        int start_idx;
        int bad;
        @(negedge clk);
        start_idx = int'(s_idx);
        s_run = 1'b1;
        bad = 0;
        for (int k = 1; k < n * len; k++) begin
            @(negedge clk);
            if (s_sof !== ((k % len) == len - 1)) bad++;
            if ((k % len) == len - 1) begin
                chk(bad == 0, "R3 period/width", bad, 0);
                bad = 0;
            end
        end
        @(negedge clk);
        chk(s_sof == 1'b0, "R3 no pulse after reload", int'(s_sof), 0);
        chk(int'(s_idx) == (start_idx + n) % (1 << S_IDXW), "R8 index step",
            int'(s_idx), (start_idx + n) % (1 << S_IDXW));
        s_run = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int v, k, idx0, pulses;
        void'($urandom(32'h5EED_0011));
        repeat (3) @(negedge clk);
        d_core_rst_n = 1'b1; d_aon_rst_n = 1'b1;
        s_core_rst_n = 1'b1; s_aon_rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk(d_rdata == 8'h20, "R2 default reg", int'(d_rdata), 32);
        chk(s_rdata == 8'h20, "R2 small reg", int'(s_rdata), 32);
        chk(d_idx == '0 && s_idx == '0, "R8 index reset", int'(d_idx), 0);

        // R1 directed and random halted writes
        s_write(8'hFF);
        chk(s_rdata == 8'h3F, "R1 reserved bits", int'(s_rdata), 8'h3F);
        s_write(8'hC0);
        chk(s_rdata == 8'h00, "R1 reserved only", int'(s_rdata), 0);
        for (int i = 0; i < 6; i++) begin
            d = 8'($urandom);
            s_write(d);
            chk(s_rdata == exp_rd(d), "R1 random write", int'(s_rdata), int'(exp_rd(d)));
            @(negedge clk);
            chk(s_rdata == exp_rd(d), "R1 read no side effect", int'(s_rdata), int'(exp_rd(d)));
        end

        // R3/R7 frame timing at random and extreme trims
        for (int i = 0; i < 4; i++) begin
            v = int'($urandom % 64);
            s_write(8'(v));
            run_small(3, exp_len(S_BASE, S_STEP, v));
        end
        s_write(8'd63);
        run_small(2, exp_len(S_BASE, S_STEP, 63));
        s_write(8'd0);
        run_small(2, exp_len(S_BASE, S_STEP, 0));

        // R5 writes while running are dropped
        s_write(8'd5);
        @(negedge clk);
        s_run = 1'b1;
        for (int i = 0; i < 3; i++) begin
            d = 8'($urandom);
            s_wr = 1'b1; s_wdata = d;
            @(negedge clk);
            s_wr = 1'b0;
            chk(s_rdata == 8'd5, "R5 running write ignored", int'(s_rdata), 5);
        end
        s_run = 1'b0;

        // R7 halted: no pulses, index stable
        idx0 = int'(s_idx);
        pulses = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (s_sof) pulses++;
        end
        chk(pulses == 0, "R7 no pulse while halted", pulses, 0);
        chk(int'(s_idx) == idx0, "R7 index held while halted", int'(s_idx), idx0);

        // R6 / R8 core reset keeps trim, clears index
        s_write(8'd0);
        run_small(1, exp_len(S_BASE, S_STEP, 0));
        s_core_rst_n = 1'b0;
        @(negedge clk);
        s_core_rst_n = 1'b1;
        @(negedge clk);
        chk(s_rdata == 8'd0, "R6 trim survives core reset", int'(s_rdata), 0);
        chk(s_idx == '0, "R8 index cleared", int'(s_idx), 0);

        // R8 wrap after 2^IDX_W frames
        run_small(1 << S_IDXW, exp_len(S_BASE, S_STEP, 0));
        chk(s_idx == '0, "R8 index wrap", int'(s_idx), 0);

        // R2 always-on reset restores default
        s_aon_rst_n = 1'b0;
        @(negedge clk);
        s_aon_rst_n = 1'b1;
        @(negedge clk);
        chk(s_rdata == 8'h20, "R2 aon reset", int'(s_rdata), 32);

        // R4 default instance, trim 32 -> 60000 clocks
        d_run = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!d_sof && k < 61000);
        chk(k + 1 == 60000, "R4 default frame length", k + 1, 60000);
        @(negedge clk);
        chk(d_idx == 14'd1, "R8 default index", int'(d_idx), 1);
        d_run = 1'b0;

        // R3 default instance, trim 0 -> 59488 clocks
        d_wr = 1'b1; d_wdata = 8'h00;
        @(negedge clk);
        d_wr = 1'b0;
        @(negedge clk);
        d_run = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!d_sof && k < 61000);
        chk(k + 1 == exp_len(59488, 16, 0), "R3 trim 0 length", k + 1, exp_len(59488, 16, 0));
        d_run = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule